// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block is a watchdog timer that software sets up and services through a small byte-wide register port. A single configuration byte sets the timeout. A 5-bit multiplier is scaled by a power of four chosen by a 2-bit resolution field, and the result is the timeout counted in strobes of a 16 Hz tick input, which is 1/16 second each. Software services the watchdog in one of two ways: it rewrites the configuration byte, or it reads the status byte.

When the countdown reaches zero, the block sets a sticky expiry flag in the status byte. The top bit of the configuration byte then picks the action:
- **Bit set:** the block clears the configuration byte, clears one enable bit in a companion control byte and pulses a system reset request.
- **Bit clear:** the block pulses an interrupt line.

After an expiry the countdown stays idle until software services it again. A multiplier of zero turns the watchdog off.

Top module: `wdt_steer`

## Requirements
- R1: Address 0 holds the configuration byte. Bit 7 is the steering bit, bits [6:2] are the multiplier and bits [1:0] are the resolution. A bus write stores all eight bits, and a read at address 0 returns them.
- R2: The timeout equals multiplier × 4^resolution strobes of `tick_16hz`. The expiry occurs on exactly that many strobes after the last restart, and never on an earlier strobe.
- R3: A write to address 0 clears the expiry flag and restarts the countdown from the newly written value.
- R4: Address 1 is the status byte, with the expiry flag in bit 7 and zeros in bits [6:0]. A read at address 1 returns the flag as it stood before the read and restarts the countdown from the stored configuration byte.
- R5: An expiry sets the expiry flag (status bit 7), and the flag stays set until the next write to address 0.
- R6: An expiry with the steering bit set drives `reset_req` high for exactly one cycle, clears the configuration byte to 0x00 and clears bit 6 of the control byte.
- R7: An expiry with the steering bit clear drives `irq_pulse` high for exactly one cycle and leaves the configuration and control bytes unchanged. `irq_pulse` and `reset_req` are never high together.
- R8: Bus writes to address 1 have no effect on the status byte.
- R9: A multiplier of zero disables the watchdog, so no expiry occurs however many ticks arrive.
- R10: After an expiry, no further expiry occurs until a write to address 0 or a read at address 1.
- R11: After reset, all three bytes read as 0x00, both outputs are low and the countdown is idle.
- R12: Address 2 is a plain read/write control byte. Address 3 reads as 0x00, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_16hz | input | 1 | One-cycle strobe at 16 Hz, one timeout unit |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a read at address 1 services the watchdog) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the stored bytes |
| irq_pulse | output | 1 | One-cycle interrupt on a steered-to-interrupt expiry |
| reset_req | output | 1 | One-cycle reset request on a steered-to-reset expiry |

## Verification
The expiry is decided at the clock edge that samples the final tick strobe. `irq_pulse`, `reset_req`, the status flag and the cleared bytes all appear right after that same edge, and the pulse falls one cycle later. The bench therefore raises each tick for one cycle and samples the outputs at the falling edge that ends that cycle, then samples once more one cycle later to confirm the pulse has dropped. Read data is combinational, so the bench captures it within the cycle of the read strobe. This matters for the status byte, because the kick caused by the read takes effect only at the next edge.

// File: rtl/wdt_steer_pkg.sv
package wdt_steer_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int MULT_W  = 5;
  localparam int RES_W   = 2;
  localparam int MULT_LO = RES_W;
  localparam int RES_MAX = (1 << RES_W) - 1;
  localparam int CNT_W   = MULT_W + 2 * RES_MAX;

  localparam logic [ADDR_W-1:0] A_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;

  localparam int STEER_BIT = 7;
  localparam int FLAG_BIT  = 7;
  localparam int CTRL_EN   = 6;

  // tick count for a configuration byte: multiplier scaled by 4^resolution
  function automatic logic [CNT_W-1:0] cfg_timeout(input logic [DATA_W-1:0] cfg);
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
    mult = cfg[MULT_LO +: MULT_W];
    res  = cfg[0 +: RES_W];
    return CNT_W'(mult) << (2 * res);
  endfunction
endpackage

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import wdt_steer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire,
  output logic             active
);
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  // a restart in the same cycle wins over a final tick
  assign expire = act_q & tick & (cnt_q == CNT_W'(1)) & ~load;
  assign active = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      act_q <= |load_val;
    end else if (tick && act_q) begin
      if (cnt_q == CNT_W'(1)) begin
        cnt_q <= '0;
        act_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_steer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cfg,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output logic [DATA_W-1:0] cfg_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              flag_q
);
  logic steer_hit;
  assign steer_hit = expire & cfg_q[STEER_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (steer_hit)   cfg_q <= '0;
      else if (wr_cfg) cfg_q <= wdata;

      if (wr_cfg)      flag_q <= 1'b0;
      else if (expire) flag_q <= 1'b1;

      if (wr_ctrl)   ctrl_q <= wdata;
      if (steer_hit) ctrl_q[CTRL_EN] <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_action.sv
module wdt_action (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic steer,
  output logic irq_pulse,
  output logic reset_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pulse <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      irq_pulse <= expire & ~steer;
      reset_req <= expire & steer;
    end
  end
endmodule

// File: rtl/wdt_steer.sv
module wdt_steer
  import wdt_steer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_16hz,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_pulse,
  output logic              reset_req
);
  logic              wr_cfg, wr_ctrl, rd_stat;
  logic              load_evt, expire_evt, run_active, wd_flag;
  logic [DATA_W-1:0] cfg_q, ctrl_q;
  logic [CNT_W-1:0]  load_val;

  assign wr_cfg   = bus_wr & (bus_addr == A_CFG);
  assign wr_ctrl  = bus_wr & (bus_addr == A_CTRL);
  assign rd_stat  = bus_rd & (bus_addr == A_STAT);
  assign load_evt = wr_cfg | rd_stat;
  assign load_val = cfg_timeout(wr_cfg ? bus_wdata : cfg_q);

  wdt_countdown u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_16hz),
    .load     (load_evt),
    .load_val (load_val),
    .expire   (expire_evt),
    .active   (run_active)
  );

  wdt_regfile u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_cfg  (wr_cfg),
    .wr_ctrl (wr_ctrl),
    .wdata   (bus_wdata),
    .expire  (expire_evt),
    .cfg_q   (cfg_q),
    .ctrl_q  (ctrl_q),
    .flag_q  (wd_flag)
  );

  wdt_action u_act (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire    (expire_evt),
    .steer     (cfg_q[STEER_BIT]),
    .irq_pulse (irq_pulse),
    .reset_req (reset_req)
  );

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = cfg_q;
      A_STAT:  bus_rdata = DATA_W'(wd_flag) << FLAG_BIT;
      A_CTRL:  bus_rdata = ctrl_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_steer_chk.sv
module wdt_steer_chk
  import wdt_steer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              irq_pulse,
  input logic              reset_req,
  input logic              expire_evt,
  input logic              load_evt,
  input logic [CNT_W-1:0]  load_val,
  input logic              run_active,
  input logic              wd_flag,
  input logic [DATA_W-1:0] cfg_q,
  input logic [DATA_W-1:0] ctrl_q
);
  a_r7_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  a_r6_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_pulse && reset_req));
  a_r6_rst_side_effects: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (cfg_q == '0 && !ctrl_q[CTRL_EN] && wd_flag));
  a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> wd_flag);
  a_r3_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CFG) |=> !wd_flag);
  a_r8_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STAT && !expire_evt) |=> $stable(wd_flag));
  a_r9_zero_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && load_val == '0) |=> !run_active);
  a_r10_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_active && !load_evt) |=> !run_active);
endmodule

bind wdt_steer wdt_steer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .irq_pulse  (irq_pulse),
  .reset_req  (reset_req),
  .expire_evt (expire_evt),
  .load_evt   (load_evt),
  .load_val   (load_val),
  .run_active (run_active),
  .wd_flag    (wd_flag),
  .cfg_q      (cfg_q),
  .ctrl_q     (ctrl_q)
);

// File: tb/wdt_steer_tb.sv
module wdt_steer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_16hz = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq_pulse, reset_req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdt_steer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_16hz(tick_16hz), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_pulse(irq_pulse), .reset_req(reset_req)
  );

  function automatic int ticks_for(input int mult, input int res);
    int t = mult;
    for (int k = 0; k < res; k++) t = t * 4;
    return t;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // one tick strobe; returns the outputs just after the sampling edge
  task automatic one_tick(output logic irq_o, output logic rst_o);
    @(negedge clk);
    tick_16hz = 1'b1;
    @(negedge clk);
    tick_16hz = 1'b0;
    irq_o = irq_pulse; rst_o = reset_req;
  endtask

  // n ticks with random gaps; returns whether any output pulse was seen
  task automatic run_ticks(input int n, output bit seen);
    logic i_o, r_o;
    seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      one_tick(i_o, r_o);
      if (i_o || r_o) seen = 1'b1;
      repeat ($urandom % 3) begin
        @(negedge clk);
        if (irq_pulse || reset_req) seen = 1'b1;
      end
    end
  endtask

  task automatic expiry_case(input bit steer, input int mult, input int res);
    logic [7:0] cfg, ctl, rd;
    logic i_o, r_o;
    bit seen;
    int n;
    cfg = {steer, mult[4:0], res[1:0]};
    ctl = 8'h40 | 8'($urandom);
    n = ticks_for(mult, res);
    bus_write(2'd2, ctl);
    bus_write(2'd0, cfg);
    run_ticks(n - 1, seen);
    check("R2 no early expiry", int'(seen), 0);
    one_tick(i_o, r_o);
    check("R6 reset_req at final tick", int'(r_o), int'(steer));
    check("R7 irq_pulse at final tick", int'(i_o), int'(!steer));
    @(negedge clk);
    check("R6/R7 pulse width one cycle", int'(irq_pulse | reset_req), 0);
    run_ticks(5, seen);
    check("R10 idle after expiry", int'(seen), 0);
    bus_read(2'd0, rd);
    check("R6/R7 cfg after expiry", rd, steer ? 0 : cfg);
    bus_read(2'd2, rd);
    check("R6/R7 ctrl after expiry", rd, steer ? (ctl & 8'hBF) : ctl);
    bus_read(2'd1, rd);
    check("R5 status flag set", rd, 8'h80);
  endtask

  initial begin
    logic [7:0] rd;
    bit seen;
    logic i_o, r_o;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    check("R11 irq low", int'(irq_pulse), 0);
    check("R11 reset_req low", int'(reset_req), 0);
    bus_read(2'd0, rd); check("R11 cfg zero", rd, 0);
    bus_read(2'd2, rd); check("R11 ctrl zero", rd, 0);
    bus_read(2'd1, rd); check("R11 status zero", rd, 0);
    run_ticks(4, seen); check("R11 idle after reset", int'(seen), 0);

    // R12 control byte and unused address
    bus_write(2'd2, 8'hA5);
    bus_read(2'd2, rd); check("R12 ctrl readback", rd, 8'hA5);
    bus_write(2'd3, 8'h5A);
    bus_read(2'd3, rd); check("R12 addr3 reads zero", rd, 0);
    bus_read(2'd2, rd); check("R12 ctrl untouched by addr3", rd, 8'hA5);

    // R1 field readback (mult 0 keeps it disabled)
    bus_write(2'd0, 8'h83);
    bus_read(2'd0, rd); check("R1 cfg readback", rd, 8'h83);

    // R9 multiplier zero disables
    run_ticks(200, seen); check("R9 no expiry with mult 0", int'(seen), 0);
    bus_read(2'd1, rd); check("R9 flag stays clear", rd, 0);

    // R3 write restarts: mult 3 res 0 -> 3 ticks
    bus_write(2'd0, 8'h0C);
    run_ticks(2, seen);
    bus_write(2'd0, 8'h0C);
    run_ticks(2, seen); check("R3 rewrite restarts count", int'(seen), 0);
    one_tick(i_o, r_o); check("R3 expiry after restart", int'(i_o), 1);

    // R8 status write ignored, R3 write clears flag
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, rd); check("R8 status write ignored", rd, 8'h80);
    bus_write(2'd0, 8'h09);   // mult 2 res 1 -> 8 ticks
    bus_read(2'd1, rd); check("R3 flag cleared by cfg write", rd, 0);

    // R4 status read kicks: the read above restarted at 8
    run_ticks(7, seen);
    bus_read(2'd1, rd); check("R4 read before expiry", rd, 0);
    run_ticks(7, seen); check("R4 kick restarts count", int'(seen), 0);
    one_tick(i_o, r_o); check("R4 expiry after kick", int'(i_o), 1);

    // R2 boundaries: smallest and largest timeouts
    expiry_case(1'b0, 1, 0);
    expiry_case(1'b1, 31, 3);

    // random cases
    for (int c = 0; c < 12; c++) begin
      int m = 1 + ($urandom % 31);
      int r = ($urandom % 4 == 0) ? 3 : int'($urandom % 3);
      expiry_case(1'($urandom), m, r);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule